// File: doc/BRIEF.md
# Strobe/Busy Parallel Port Controller

This block sits between a host register bus and an 8-bit parallel peripheral link. For output, the host writes a byte. The controller puts the byte on the data lines and lets it settle for a set number of clocks. It then drives an active-low strobe pulse of programmable width. After that it waits for the device's BUSY feedback to clear before it takes another byte. For input, a rising edge on the device's data-ready line latches the input byte and sets an input-buffer-full flag. Reading the byte clears the flag.

Software can run the link in either of two ways. It can poll a status register, which shows synchronized BUSY, buffer-full, output-ready and two sticky overrun flags. Or it can set a control bit so that a level interrupt line follows the pending conditions. The interrupt clears when the host reads the input byte or writes the next output byte. On the output side, the interrupt source can be either the return to ready or the device acknowledge. Every device input goes through a two-flop synchronizer before any logic uses it.

Top module: `par_link_host`

## Requirements
- R1: After reset, strobe_n is 1, pd_out is 0, irq is 0, and the status register (address 2) reads 0x04.
- R2: A write to address 0 while output-ready puts the byte on pd_out at the write edge. strobe_n falls exactly SETUP_CY clocks later, provided synchronized BUSY is low. It stays low for exactly STB_CY clocks. pd_out does not change from the write until the next accepted write.
- R3: Output-ready (status bit 2) is 0 from an accepted write until three clocks after strobe_n rises. It is also 0 whenever synchronized BUSY is 1. No strobe starts while synchronized BUSY is 1.
- R4: A write to address 0 while output-ready is 0 is rejected, and pd_out keeps its byte. The write sets sticky status bit 3. Writing 1 to bit 3 of address 2 clears it.
- R5: A rising edge on dev_ready latches pd_in into the input data register (read at address 1) and sets IBF (status bit 1) at the third clock edge after the rise. A read of address 1 clears IBF.
- R6: A data-ready rise while IBF is set keeps the byte already held and sets sticky status bit 4. Writing 1 to bit 4 of address 2 clears it.
- R7: With control bit 0 (address 3) set, irq is 1 while IBF is set. It drops after the read of address 1.
- R8: With control bit 0 set and control bit 1 clear, a return of output-ready to 1 sets the output event (status bit 5) and raises irq. The next accepted write clears it. So does writing 1 to bit 5 of address 2.
- R9: With control bits 0 and 1 set, the output event is set only by a rising edge of the synchronized dev_ack. It is not set by the return to ready.
- R10: With control bit 0 clear, irq stays 0 while the status bits still report IBF and the output event.
- R11: Status bit 0 shows dev_busy delayed by exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (a read of address 1 clears IBF) |
| reg_addr | input | 2 | Register address: 0 output byte, 1 input byte, 2 status, 3 control |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt request |
| pd_out | output | DW | Output data lines |
| strobe_n | output | 1 | Active-low data strobe to the device |
| dev_busy | input | 1 | Device busy feedback (asynchronous) |
| dev_ack | input | 1 | Device acknowledge (asynchronous) |
| pd_in | input | DW | Input data lines |
| dev_ready | input | 1 | Device data-ready (asynchronous) |

## Verification
The bench drives inputs on falling edges and samples on falling edges, counting each rising edge in between. The new output byte shows on pd_out at the first falling edge after the write. The strobe falls SETUP_CY edges after the write and rises STB_CY edges after it falls, and a device model counts both windows cycle by cycle. Synchronized BUSY is due two edges after dev_busy changes, and IBF with its data is due three edges after dev_ready rises. Each of these is sampled one edge early, where the old value is expected, and again at the due edge. The output event and its interrupt trail the return to ready by one more edge, so the bench checks irq one sample after it first sees ready.

// File: rtl/par_link_host.sv
`timescale 1ns/1ps
module par_link_host #(
  parameter int DW       = 8,
  parameter int SETUP_CY = 2,
  parameter int STB_CY   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic [DW-1:0] pd_out,
  output logic          strobe_n,
  input  logic          dev_busy,
  input  logic          dev_ack,
  input  logic [DW-1:0] pd_in,
  input  logic          dev_ready
);

  localparam int GUARD_CY = 3;
  localparam int MAXC = (SETUP_CY > STB_CY) ? ((SETUP_CY > GUARD_CY) ? SETUP_CY : GUARD_CY)
                                            : ((STB_CY > GUARD_CY) ? STB_CY : GUARD_CY);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STB, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    sy1, sy2;
  logic          dr_q, ack_q, rdy_q;
  logic [DW-1:0] rx_data;
  logic          ibf, tx_ovr, rx_ovr, tx_evt;
  logic [1:0]    ctl;

  wire busy_s   = sy2[0];
  wire dr_s     = sy2[1];
  wire ack_s    = sy2[2];
  wire dr_rise  = dr_s & ~dr_q;
  wire ack_rise = ack_s & ~ack_q;
  wire tx_ready = (st == S_IDLE) & ~busy_s;

  wire wr_tx  = reg_wr & (reg_addr == 2'd0);
  wire wr_ok  = wr_tx & tx_ready;
  wire wr_st  = reg_wr & (reg_addr == 2'd2);
  wire wr_ctl = reg_wr & (reg_addr == 2'd3);
  wire rd_rx  = reg_rd & (reg_addr == 2'd1);

  wire evt_set = ctl[1] ? ack_rise : (tx_ready & ~rdy_q);

  assign strobe_n = (st != S_STB);
  assign irq      = ctl[0] & (ibf | tx_evt);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = pd_out;
      2'd1:    reg_rdata = rx_data;
      2'd2:    reg_rdata = {{(DW-6){1'b0}}, tx_evt, rx_ovr, tx_ovr, tx_ready, ibf, busy_s};
      default: reg_rdata = {{(DW-2){1'b0}}, ctl};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0;
      dr_q <= 1'b0; ack_q <= 1'b0; rdy_q <= 1'b1;
    end else begin
      sy1 <= {dev_ack, dev_ready, dev_busy};
      sy2 <= sy1;
      dr_q <= dr_s; ack_q <= ack_s; rdy_q <= tx_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; pd_out <= '0;
    end else begin
      case (st)
        S_IDLE: if (wr_ok) begin
          pd_out <= reg_wdata; st <= S_SETUP; cnt <= '0;
        end
        S_SETUP: if (cnt >= CW'(SETUP_CY - 1)) begin
          if (!busy_s) begin st <= S_STB; cnt <= '0; end
        end else cnt <= cnt + 1'b1;
        S_STB: if (cnt == CW'(STB_CY - 1)) begin
          st <= S_HOLD; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == CW'(GUARD_CY - 1)) begin
          st <= S_IDLE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0; ibf <= 1'b0; rx_ovr <= 1'b0;
      tx_ovr <= 1'b0; tx_evt <= 1'b0; ctl <= '0;
    end else begin
      if (dr_rise && ibf && !rd_rx) rx_ovr <= 1'b1;
      else if (wr_st && reg_wdata[4]) rx_ovr <= 1'b0;

      if (dr_rise && (!ibf || rd_rx)) begin
        rx_data <= pd_in; ibf <= 1'b1;
      end else if (rd_rx) ibf <= 1'b0;

      if (wr_tx && !tx_ready) tx_ovr <= 1'b1;
      else if (wr_st && reg_wdata[3]) tx_ovr <= 1'b0;

      if (wr_ok || (wr_st && reg_wdata[5])) tx_evt <= 1'b0;
      else if (evt_set) tx_evt <= 1'b1;

      if (wr_ctl) ctl <= reg_wdata[1:0];
    end
  end

  p_no_strobe_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> !$past(busy_s));

  p_lines_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(pd_out));

  p_reject_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && !tx_ready) |=> ($stable(pd_out) && tx_ovr));

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovr && !(wr_st && reg_wdata[3])) |=> tx_ovr);

  p_ibf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dr_rise |=> ibf);

  p_ibf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !dr_rise) |=> !ibf);

  p_rx_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rise && ibf && !rd_rx) |=> (rx_ovr && $stable(rx_data)));

  p_polled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[0] |-> !irq);

endmodule

// File: tb/test_par_link_host.sv
`timescale 1ns/1ps
module test_par_link_host;
  localparam int SETUP_CY = 2;
  localparam int STB_CY   = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, pd_out, pd_in = '0;
  logic       irq, strobe_n, dev_ready = 1'b0;
  logic       busy_dev = 1'b0, busy_man = 1'b0, ack_dev = 1'b0;
  wire        dev_busy = busy_dev | busy_man;

  par_link_host #(.DW(8), .SETUP_CY(SETUP_CY), .STB_CY(STB_CY)) i_par_link_host (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .pd_out, .strobe_n, .dev_busy, .dev_ack(ack_dev), .pd_in, .dev_ready);

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int         busy_len = 0, busy_left = 0, low_cnt = 0, since_chg = 0, got_n = 0;
  bit         ack_en = 1'b1;
  logic [7:0] last_out = '0, cap = '0;
  logic       prev_stb = 1'b1;
  logic [7:0] got [0:255];

  always @(negedge clk) begin
    if (rst_n) begin
      ack_dev = 1'b0;
      if (busy_dev) begin
        busy_left--;
        if (busy_left <= 0) begin busy_dev = 1'b0; if (ack_en) ack_dev = 1'b1; end
      end
      if (pd_out !== last_out) since_chg = 0; else since_chg++;
      last_out = pd_out;
      if (!strobe_n) begin
        if (prev_stb) begin
          chk("R2 setup clocks before strobe", since_chg, SETUP_CY);
          cap = pd_out; low_cnt = 0;
        end
        low_cnt++;
        if (pd_out !== cap) chk("R2 lines stable during strobe", pd_out, cap);
      end else if (!prev_stb) begin
        chk("R2 strobe low width", low_cnt, STB_CY);
        if (got_n < 256) got[got_n] = cap;
        got_n++;
        if (busy_len > 0) begin busy_dev = 1'b1; busy_left = busy_len; end
        else if (ack_en) ack_dev = 1'b1;
      end
      prev_stb = strobe_n;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    peek(2, s);
    while (!s[2]) begin @(negedge clk); peek(2, s); end
  endtask

  task automatic dr_pulse(input logic [7:0] b);
    @(negedge clk); pd_in = b; dev_ready = 1'b1;
    repeat (4) @(negedge clk);
    dev_ready = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++; vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] s, d, b, b2;
    logic [7:0] sent [0:63];
    int n;
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(2, s);
    chk("R1 status after reset", s, 8'h04);
    chk("R1 strobe_n after reset", strobe_n, 1'b1);
    chk("R1 pd_out after reset", pd_out, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);

    busy_man = 1'b1;
    @(negedge clk); peek(2, s); chk("R11 busy one edge late", s[0], 1'b0);
    @(negedge clk); peek(2, s); chk("R11 busy after two edges", s[0], 1'b1);
    chk("R3 not ready while busy", s[2], 1'b0);
    wr(0, 8'hA5);
    peek(2, s);
    chk("R4 rejected write keeps lines", pd_out, 8'h00);
    chk("R4 tx overrun set", s[3], 1'b1);
    repeat (4) @(negedge clk);
    chk("R3 no strobe while busy", strobe_n, 1'b1);
    wr(2, 8'h08); peek(2, s); chk("R4 tx overrun cleared", s[3], 1'b0);
    busy_man = 1'b0;
    repeat (3) @(negedge clk);

    n = 0; ack_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      busy_len = $urandom_range(0, 5);
      wait_ready();
      b = 8'($urandom);
      sent[n] = b; n++;
      wr(0, b);
      chk("R2 byte on lines", pd_out, b);
      peek(2, s); chk("R3 not ready after write", s[2], 1'b0);
      if ($urandom_range(0, 3) == 0) begin
        wr(0, ~b);
        peek(2, s);
        chk("R4 busy-time write keeps lines", pd_out, b);
        chk("R4 overrun flagged", s[3], 1'b1);
        wr(2, 8'h08);
      end
    end
    wait_ready();
    chk("R2 bytes delivered", got_n, n);
    for (int i = 0; i < n; i++) chk("R2 delivered byte", got[i], sent[i]);

    wr(2, 8'h20); wr(3, 8'h01);
    chk("R8 irq idle before transfer", irq, 1'b0);
    busy_len = 3;
    wr(0, 8'h3C);
    wait_ready(); @(negedge clk);
    chk("R8 irq on return to ready", irq, 1'b1);
    wr(0, 8'h3D);
    chk("R8 irq cleared by next write", irq, 1'b0);
    wait_ready(); @(negedge clk);
    chk("R8 irq again after second byte", irq, 1'b1);
    wr(2, 8'h20);
    chk("R8 irq cleared by status write", irq, 1'b0);

    wr(3, 8'h03); ack_en = 1'b0; busy_len = 2;
    wr(0, 8'h77);
    wait_ready(); repeat (3) @(negedge clk);
    chk("R9 no irq on ready in ack mode", irq, 1'b0);
    ack_en = 1'b1;
    wr(0, 8'h78);
    wait_ready(); repeat (3) @(negedge clk);
    chk("R9 irq on acknowledge", irq, 1'b1);
    wr(3, 8'h00);
    peek(2, s);
    chk("R10 event still reported", s[5], 1'b1);
    chk("R10 irq low in polled mode", irq, 1'b0);
    wr(2, 8'h38);

    wr(3, 8'h01);
    @(negedge clk); pd_in = 8'hC3; dev_ready = 1'b1;
    @(negedge clk);
    @(negedge clk); peek(2, s); chk("R5 IBF not yet set", s[1], 1'b0);
    @(negedge clk); peek(2, s); chk("R5 IBF at third edge", s[1], 1'b1);
    chk("R7 irq on IBF", irq, 1'b1);
    dev_ready = 1'b0;
    repeat (2) @(negedge clk);
    rd(1, d);
    chk("R5 latched byte", d, 8'hC3);
    peek(2, s); chk("R5 IBF cleared by read", s[1], 1'b0);
    chk("R7 irq cleared by read", irq, 1'b0);
    wr(3, 8'h00);

    for (int i = 0; i < 30; i++) begin
      b = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        b2 = 8'($urandom);
        dr_pulse(b); dr_pulse(b2);
        peek(2, s);
        chk("R6 rx overrun set", s[4], 1'b1);
        chk("R10 IBF without irq", irq, 1'b0);
        rd(1, d); chk("R6 first byte kept", d, b);
        wr(2, 8'h10); peek(2, s); chk("R6 rx overrun cleared", s[4], 1'b0);
      end else begin
        dr_pulse(b);
        rd(1, d); chk("R5 random input byte", d, b);
        peek(2, s); chk("R5 IBF clear after read", s[1], 1'b0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule